// File: doc/BRIEF.md
# Parallel Sample Readout with Data-Ready Flag

This block sits at the parallel end of a converter data path. Each time the converter raises its update strobe, the block captures the new 16-bit sample and moves it into an output register two clock edges later. A host reads that register over a 16-bit bus. The bus is three-state, and it is modelled here as an output-enable plus a data vector. An active-low data-ready flag falls when a fresh word is waiting. It rises again when a read finishes. When nobody reads the word, the flag gives a fixed two-clock high pulse just before the next word lands.

The read controls are active-low chip-select and read. They are sampled on the master clock and do not act asynchronously. The output register is never changed while the bus is enabled. An update that arrives during a long read is held back and loads on the edge at which the read ends.

A resync input restarts the flag signalling. After a resync the block discards a configurable number of updates, because the converter's results are not yet valid. It then loads the next update and marks it with a one-cycle first-valid pulse.

Top module: `sample_readout`

## Requirements
- R1: The bus enable output is high in the cycle after a clock edge that samples both read and chip-select low. It is low in the cycle after any edge that samples either of them high.
- R2: While the bus enable is low, all 16 data outputs read as zero, which stands for high impedance. While the bus enable is high, the data outputs carry the output register, with bit 15 as the MSB and bit 0 as the LSB.
- R3: The sample value is captured at the edge that samples the update strobe high. Counting that edge as the first, the output register loads the value at the third edge, and data-ready goes low after that same edge.
- R4: The edge that ends an enabled read sets data-ready high, unless a deferred update loads at that same edge (see R6).
- R5: An update strobe sampled while data-ready is low drives data-ready high. It then stays high for exactly two cycles before the new word lowers it.
- R6: The output register does not change while the bus enable stays high. An update that becomes due during a read loads at the edge that ends the read, and data-ready goes low at that edge.
- R7: After reset, data-ready is high, the bus enable is low, the data outputs are zero and first-valid is low. The first update after reset lowers data-ready without a first-valid pulse.
- R8: A resync pulse drives data-ready high at the next edge. The next SETTLE_UPD updates (3 by default) leave the output register unchanged and data-ready high. The update after those loads the register, lowers data-ready and raises first-valid for one cycle.
- R9: First-valid is high only in a cycle where data-ready has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe from the converter, one cycle wide |
| sample_i | input | 16 | Sample word, valid while upd_i is high |
| resync_i | input | 1 | Restarts data-ready signalling |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read |
| bus_oe_o | output | 1 | Bus enable; low means the bus is at high impedance |
| bus_q_o | output | 16 | Bus data, bit 15 is the MSB |
| drdy_n_o | output | 1 | Active-low data-ready flag |
| first_valid_o | output | 1 | One-cycle mark on the first valid word after a resync |

## Verification
Some properties are checked on every cycle: bus enable following the sampled read and chip-select, zero data while the bus is disabled, a frozen register during reads, the rise of data-ready after an unread update strobe and after a resync, and first-valid appearing only with a falling data-ready. Other behaviour can only be shown by the bench scenarios. These cover the exact three-edge update latency, the two-cycle pulse width, a deferred load at the end of a long read, the count of discarded updates after a resync, and the sample values read back from the bus.

// File: rtl/readout_pkg.sv
package readout_pkg;
  typedef struct packed {
    logic active;  // this edge sees a qualified read
    logic done;    // this edge ends an enabled read
    logic hold;    // enabled read continues past this edge
  } rd_evt_t;
endpackage

// File: rtl/readout_rd_ctl.sv
module readout_rd_ctl
  import readout_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n_i,
  input  logic    rd_n_i,
  output logic    oe_o,
  output rd_evt_t evt_o
);
  logic oe_q, oe_d;

  always_comb begin
    evt_o.active = ~rd_n_i & ~cs_n_i;
    evt_o.done   = oe_q & ~evt_o.active;
    evt_o.hold   = oe_q & evt_o.active;
    oe_d         = evt_o.active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  assign oe_o = oe_q;
endmodule

// File: rtl/readout_upd_pipe.sv
module readout_upd_pipe #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              flush_i,
  input  logic              hold_i,
  output logic              load_o,
  output logic [DATA_W-1:0] stage_o
);
  logic              s1_q, s1_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] stage_q, stage_d;
  logic              stage_en;

  always_comb begin
    load_o   = pend_q & ~hold_i & ~flush_i;
    stage_en = upd_i;
    stage_d  = sample_i;
    s1_d     = upd_i & ~flush_i;
    if (flush_i)     pend_d = 1'b0;
    else if (s1_q)   pend_d = 1'b1;
    else if (load_o) pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/readout_flag_ctl.sv
module readout_flag_ctl #(
  parameter int SETTLE_UPD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic resync_i,
  input  logic upd_i,
  input  logic load_i,
  input  logic rd_done_i,
  output logic commit_o,
  output logic drdy_n_o,
  output logic first_o
);
  localparam int CW = $clog2(SETTLE_UPD + 2);
  localparam logic [CW-1:0] SKIP_INIT = CW'(SETTLE_UPD);

  logic          drdy_q, drdy_d;
  logic [CW-1:0] skip_q, skip_d;
  logic          armed_q, armed_d;
  logic          fv_q, fv_d;

  always_comb begin
    drdy_d   = drdy_q;
    skip_d   = skip_q;
    armed_d  = armed_q;
    fv_d     = 1'b0;
    commit_o = 1'b0;
    if (resync_i) begin
      drdy_d  = 1'b1;
      skip_d  = SKIP_INIT;
      armed_d = 1'b1;
    end else if (load_i) begin
      if (skip_q != '0) begin
        skip_d = skip_q - 1'b1;
      end else begin
        commit_o = 1'b1;
        drdy_d   = upd_i;
        fv_d     = armed_q & ~upd_i;
        if (!upd_i) armed_d = 1'b0;
      end
    end else if (upd_i || rd_done_i) begin
      drdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q  <= 1'b1;
      skip_q  <= '0;
      armed_q <= 1'b0;
      fv_q    <= 1'b0;
    end else begin
      drdy_q  <= drdy_d;
      skip_q  <= skip_d;
      armed_q <= armed_d;
      fv_q    <= fv_d;
    end
  end

  assign drdy_n_o = drdy_q;
  assign first_o  = fv_q;
endmodule

// File: rtl/sample_readout.sv
module sample_readout
  import readout_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETTLE_UPD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              resync_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] bus_q_o,
  output logic              drdy_n_o,
  output logic              first_valid_o
);
  localparam int SYNC_ST = 2;

  logic [SYNC_ST-1:0] rst_pipe_q;
  logic               rst_n_sync;
  rd_evt_t            rd_evt;
  logic               oe;
  logic               load, commit;
  logic [DATA_W-1:0]  stage;
  logic [DATA_W-1:0]  word_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_ST-2:0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[SYNC_ST-1];

  readout_rd_ctl u_rd (
    .clk(clk), .rst_n(rst_n_sync), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .oe_o(oe), .evt_o(rd_evt)
  );

  readout_upd_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_n_sync), .upd_i(upd_i), .sample_i(sample_i),
    .flush_i(resync_i), .hold_i(rd_evt.hold), .load_o(load), .stage_o(stage)
  );

  readout_flag_ctl #(.SETTLE_UPD(SETTLE_UPD)) u_flag (
    .clk(clk), .rst_n(rst_n_sync), .resync_i(resync_i), .upd_i(upd_i),
    .load_i(load), .rd_done_i(rd_evt.done), .commit_o(commit),
    .drdy_n_o(drdy_n_o), .first_o(first_valid_o)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  word_q <= '0;
    else if (commit)  word_q <= stage;
  end

  assign bus_oe_o = oe;
  assign bus_q_o  = oe ? word_q : '0;
endmodule

// File: rtl/sample_readout_chk.sv
module sample_readout_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_i,
  input logic              resync_i,
  input logic              cs_n_i,
  input logic              rd_n_i,
  input logic              bus_oe_o,
  input logic [DATA_W-1:0] bus_q_o,
  input logic              drdy_n_o,
  input logic              first_valid_o
);
  assert_bus_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_i && !cs_n_i) |=> bus_oe_o);

  assert_bus_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n_i || cs_n_i) |=> !bus_oe_o);

  assert_bus_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> (bus_q_o == '0));

  assert_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && !rd_n_i && !cs_n_i) |=> $stable(bus_q_o));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !drdy_n_o && !resync_i) |=> drdy_n_o);

  assert_resync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync_i |=> drdy_n_o);

  assert_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid_o |-> $fell(drdy_n_o));
endmodule

bind sample_readout sample_readout_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .upd_i(upd_i), .resync_i(resync_i),
  .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .bus_oe_o(bus_oe_o), .bus_q_o(bus_q_o),
  .drdy_n_o(drdy_n_o), .first_valid_o(first_valid_o)
);

// File: tb/sample_readout_bench.sv
module sample_readout_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_i, resync_i, cs_n_i, rd_n_i;
  logic [15:0] sample_i;
  logic        bus_oe_o, drdy_n_o, first_valid_o;
  logic [15:0] bus_q_o;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  sample_readout u_sample_readout (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .sample_i(sample_i),
    .resync_i(resync_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .bus_oe_o(bus_oe_o), .bus_q_o(bus_q_o), .drdy_n_o(drdy_n_o),
    .first_valid_o(first_valid_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // strobe one update, leaving time at the strobe edge (edge 1)
  task automatic strobe(input logic [15:0] v);
    upd_i = 1'b1; sample_i = v;
    step();
    upd_i = 1'b0; sample_i = 16'h0;
  endtask

  task automatic read_word(input string req, input logic [15:0] exp);
    rd_n_i = 1'b0; cs_n_i = 1'b0;
    step();
    check({req, " oe"}, {15'h0, bus_oe_o}, 16'h1);
    check({req, " data"}, bus_q_o, exp);
    rd_n_i = 1'b1; cs_n_i = 1'b1;
    step();
    check({req, " oe off R1"}, {15'h0, bus_oe_o}, 16'h0);
    check({req, " bus zero R2"}, bus_q_o, 16'h0);
  endtask

  task automatic t_reset();
    check("R7 drdy", {15'h0, drdy_n_o}, 16'h1);
    check("R7 oe", {15'h0, bus_oe_o}, 16'h0);
    check("R7 bus", bus_q_o, 16'h0);
    check("R7 first", {15'h0, first_valid_o}, 16'h0);
  endtask

  task automatic t_update();
    strobe(16'hA5C3);
    check("R3 edge1 drdy", {15'h0, drdy_n_o}, 16'h1);
    step();
    check("R3 edge2 drdy", {15'h0, drdy_n_o}, 16'h1);
    step();
    check("R3 edge3 drdy", {15'h0, drdy_n_o}, 16'h0);
    check("R7 no first", {15'h0, first_valid_o}, 16'h0);
    read_word("R2 msb", 16'hA5C3);
    check("R4 drdy after read", {15'h0, drdy_n_o}, 16'h1);
  endtask

  task automatic t_unread();
    strobe(16'h1111); step(); step();
    check("R3 word B ready", {15'h0, drdy_n_o}, 16'h0);
    step();
    check("R5 stays low", {15'h0, drdy_n_o}, 16'h0);
    strobe(16'h2222);
    check("R5 pulse c1", {15'h0, drdy_n_o}, 16'h1);
    step();
    check("R5 pulse c2", {15'h0, drdy_n_o}, 16'h1);
    step();
    check("R5 pulse end", {15'h0, drdy_n_o}, 16'h0);
    read_word("R5 word C", 16'h2222);
  endtask

  task automatic t_cs_high();
    rd_n_i = 1'b0; cs_n_i = 1'b1;
    step();
    check("R1 cs high no oe", {15'h0, bus_oe_o}, 16'h0);
    check("R2 cs high bus", bus_q_o, 16'h0);
    rd_n_i = 1'b1;
    step();
  endtask

  task automatic t_read_defer();
    strobe(16'h3333); step(); step();
    rd_n_i = 1'b0; cs_n_i = 1'b0;
    step();
    check("R6 read starts", bus_q_o, 16'h3333);
    strobe(16'h4444);
    for (int i = 0; i < 4; i++) begin
      check("R6 held during read", bus_q_o, 16'h3333);
      step();
    end
    check("R6 held drdy high", {15'h0, drdy_n_o}, 16'h1);
    rd_n_i = 1'b1; cs_n_i = 1'b1;
    step();
    check("R6 load at read end", {15'h0, drdy_n_o}, 16'h0);
    read_word("R6 deferred word", 16'h4444);
  endtask

  task automatic t_resync();
    strobe(16'h5555); step(); step();
    check("R8 pre drdy", {15'h0, drdy_n_o}, 16'h0);
    resync_i = 1'b1;
    step();
    resync_i = 1'b0;
    check("R8 drdy high", {15'h0, drdy_n_o}, 16'h1);
    for (int k = 0; k < 3; k++) begin
      strobe(16'h6000 + 16'(k)); step(); step();
      check("R8 discard drdy", {15'h0, drdy_n_o}, 16'h1);
      check("R8 discard first", {15'h0, first_valid_o}, 16'h0);
    end
    read_word("R8 register kept", 16'h5555);
    strobe(16'h7777); step(); step();
    check("R8 valid drdy", {15'h0, drdy_n_o}, 16'h0);
    check("R9 first pulse", {15'h0, first_valid_o}, 16'h1);
    step();
    check("R8 first one cycle", {15'h0, first_valid_o}, 16'h0);
    read_word("R8 valid word", 16'h7777);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; upd_i = 1'b0; resync_i = 1'b0;
    cs_n_i = 1'b1; rd_n_i = 1'b1; sample_i = 16'h0;
    #21;
    t_reset();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_update();
    t_unread();
    t_cs_high();
    t_read_defer();
    t_resync();
    finish_run();
  end
endmodule